// File: doc/BRIEF.md
# Audio Frame Sequencer with Frame Interrupt

This block is the timing backbone of a game-console sound unit. It counts clock cycles and hands out two kinds of one-cycle strobes to the sound channels. The quarter-frame strobe drives the envelope-style units. The half-frame strobe drives the length and sweep units. It runs either a 4-step or a 5-step sequence. In 4-step mode it can also raise a frame interrupt.

Software controls the block through a control write and a status read. The control write selects the mode and the interrupt inhibit. It does not act at once: it waits three or four cycles, depending on an internal even/odd toggle, and then restarts the sequence from zero. The status read reports the frame interrupt flag, together with the channel activity and sample-interrupt bits passed in from outside. The read also clears the frame interrupt flag. The interrupt flag and the interrupt line rise on different cycles near the end of a 4-step sequence.

Top module: `frame_seq`

## Requirements
- R1: After synchronous reset, quarter_o, half_o and irq_o are 0, and status bit 6 is 0. The block starts in 4-step mode with the inhibit clear, counting from 0, with the toggle at 0.
- R2: Let clock edges be numbered from the start of a sequence. In 4-step mode quarter_o is high for one cycle after edges 7457, 14913, 22372 and 29830. Edge 29830 also restarts the count, so the sequence repeats every 29830 edges.
- R3: In 4-step mode half_o is high after edge 14913 (step 1) and after edge 29829. It is low after edge 29830.
- R4: In 4-step mode with the inhibit clear, the frame flag (status bit 6) becomes 1 after edge 29828. It is set again on edges 29829 and 29830.
- R5: irq_o rises one cycle after the edge-29829 event, so it is high after edge 29830. It stays high while the flag is 1, and irq_o is never 1 while the flag is 0.
- R6: A status read (rd_en high at an edge) clears the flag at that edge, and irq_o drops at the same edge. A flag set on the same edge takes priority over the read.
- R7: A control write presented at an edge where the toggle is 0 takes effect on the 4th edge, counting the write edge as the 1st. If the toggle is 1, it takes effect on the 3rd edge. The toggle flips on every edge. The edge where the write takes effect loads bit 7 as the mode (1 = 5-step) and bit 6 as the inhibit, and resets the count and the step to 0.
- R8: In 5-step mode quarter_o is high after edges 7458, 14913, 22372 and 37282, but not after edge 29830. half_o is high after edges 14913 and 37281. The sequence restarts at edge 37282, and the flag is never set.
- R9: When a write with bit 6 = 1 takes effect, it clears the flag and drops irq_o. While the inhibit is 1, the flag is not set.
- R10: status_o bits 4..0 equal len_nz_i, bit 7 equals dmc_irq_i, and bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 8 | Control value; bit 7 mode, bit 6 inhibit |
| rd_en | input | 1 | Status read strobe; clears the frame flag |
| dmc_irq_i | input | 1 | Sample-channel interrupt, reported in status bit 7 |
| len_nz_i | input | 5 | Channel length-nonzero bits, reported in status bits 4..0 |
| quarter_o | output | 1 | Quarter-frame strobe |
| half_o | output | 1 | Half-frame strobe |
| irq_o | output | 1 | Frame interrupt line |
| status_o | output | 8 | Status byte; bit 6 is the frame flag |

## Verification
The hardest situation to reach is the parity-dependent write delay. It only shows up as an exact shift of the next sequence's first strobe. The bench issues writes on a chosen even or odd cycle of its own cycle count, derives the toggle value from that count, and then checks the strobe on its exact cycle and on the cycles either side of it. The inhibit-clear case needs the flag already set. So the bench first runs a full 4-step sequence, and then lands an inhibiting write while the flag and the line are high.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int CW  = 16,
  parameter int S4A = 7457,
  parameter int S4B = 14913,
  parameter int S4C = 22372,
  parameter int S4D = 29830,
  parameter int S5A = 7458,
  parameter int S5B = 14913,
  parameter int S5C = 22372,
  parameter int S5D = 29830,
  parameter int S5E = 37282
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       dmc_irq_i,
  input  logic [4:0] len_nz_i,
  output logic       quarter_o,
  output logic       half_o,
  output logic       irq_o,
  output logic [7:0] status_o
);
  localparam logic [CW-1:0] EARLY4 = CW'(S4D - 2);
  localparam logic [CW-1:0] LATE4  = CW'(S4D - 1);
  localparam logic [CW-1:0] LATE5  = CW'(S5E - 1);

  logic [CW-1:0] cnt_q, nxt, target;
  logic [2:0]    step_q, pend_q;
  logic [1:0]    pval_q;
  logic          mode_q, inh_q, flag_q, arm_q, tog_q;
  logic          hit, last, early4, late4, late5, set_f, apply, flag_d;

  assign nxt = cnt_q + 1'b1;

  always_comb begin
    target = '0;
    if (mode_q) begin
      case (step_q)
        3'd0: target = CW'(S5A);
        3'd1: target = CW'(S5B);
        3'd2: target = CW'(S5C);
        3'd3: target = CW'(S5D);
        3'd4: target = CW'(S5E);
        default: target = '0;
      endcase
    end else begin
      case (step_q)
        3'd0: target = CW'(S4A);
        3'd1: target = CW'(S4B);
        3'd2: target = CW'(S4C);
        3'd3: target = CW'(S4D);
        default: target = '0;
      endcase
    end
  end

  assign hit    = (nxt == target);
  assign last   = mode_q ? (step_q == 3'd4) : (step_q == 3'd3);
  assign early4 = !mode_q && (nxt == EARLY4);
  assign late4  = !mode_q && (nxt == LATE4);
  assign late5  = mode_q && (nxt == LATE5);
  assign set_f  = !inh_q && (early4 || late4 || (hit && last && !mode_q));
  assign apply  = (pend_q == 3'd1) && !wr_en;

  always_comb begin
    flag_d = (flag_q && !rd_en) || set_f;
    if (apply && pval_q[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      step_q    <= '0;
      pend_q    <= '0;
      pval_q    <= '0;
      mode_q    <= 1'b0;
      inh_q     <= 1'b0;
      flag_q    <= 1'b0;
      arm_q     <= 1'b0;
      tog_q     <= 1'b0;
      quarter_o <= 1'b0;
      half_o    <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      tog_q     <= ~tog_q;
      quarter_o <= hit && !(mode_q && step_q == 3'd3);
      half_o    <= (hit && step_q == 3'd1) || late4 || late5;
      arm_q     <= late4 && !inh_q;
      flag_q    <= flag_d;
      irq_o     <= flag_d && (irq_o || arm_q);
      if (hit && last) begin
        cnt_q  <= '0;
        step_q <= '0;
      end else begin
        cnt_q <= nxt;
        if (hit) step_q <= step_q + 3'd1;
      end
      if (wr_en) begin
        pend_q <= tog_q ? 3'd2 : 3'd3;
        pval_q <= wr_data[7:6];
      end else if (pend_q != 3'd0) begin
        pend_q <= pend_q - 3'd1;
      end
      if (apply) begin
        mode_q <= pval_q[1];
        inh_q  <= pval_q[0];
        cnt_q  <= '0;
        step_q <= '0;
      end
    end
  end

  assign status_o = {dmc_irq_i, flag_q, 1'b0, len_nz_i};

  // R5
  line_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_q);

  // R5
  line_rise_after_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(arm_q));

  // R9
  flag_rise_not_inhibited_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> !$past(inh_q));

  // R8
  flag_rise_four_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> !$past(mode_q));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !set_f) |=> !flag_q && !irq_o);

  // R7
  write_pends_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pend_q == 3'd2 || pend_q == 3'd3));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(S5E));
endmodule

// File: tb/sim_frame_seq.sv
module sim_frame_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       dmc_irq_i = 1'b0;
  logic [4:0] len_nz_i = '0;
  logic       quarter_o, half_o, irq_o;
  logic [7:0] status_o;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  frame_seq u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .dmc_irq_i(dmc_irq_i), .len_nz_i(len_nz_i),
    .quarter_o(quarter_o), .half_o(half_o), .irq_o(irq_o), .status_o(status_o));

  always #10 clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic go(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic chk_out(input int at, input string tag, input bit q, input bit h,
                         input bit fl, input bit ir);
    go(at);
    check(quarter_o == q, {tag, " quarter"}, quarter_o, q);
    check(half_o == h, {tag, " half"}, half_o, h);
    check(status_o[6] == fl, {tag, " flag"}, status_o[6], fl);
    check(irq_o == ir, {tag, " irq"}, irq_o, ir);
  endtask

  task automatic write(input int parity, input logic [7:0] v, output int applied);
    while ((cyc & 1) != parity) @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    applied = cyc + (((cyc & 1) == 1) ? 3 : 4);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check(quarter_o == 0 && half_o == 0 && irq_o == 0, "R1 outputs", {quarter_o, half_o, irq_o}, 0);
    check(status_o[6] == 0, "R1 flag", status_o[6], 0);
    len_nz_i = 5'b10110;
    dmc_irq_i = 1'b1;
    #1;
    check(status_o == 8'b1001_0110, "R10 status", status_o, 8'h96);
    len_nz_i = 5'b01001;
    dmc_irq_i = 1'b0;
    #1;
    check(status_o == 8'b0000_1001, "R10 status", status_o, 8'h09);
  endtask

  task automatic t_four_step;
    chk_out(7456, "R2 pre", 0, 0, 0, 0);
    chk_out(7457, "R2 step0", 1, 0, 0, 0);
    chk_out(14913, "R3 step1", 1, 1, 0, 0);
    chk_out(22372, "R2 step2", 1, 0, 0, 0);
    chk_out(29827, "R4 before", 0, 0, 0, 0);
    chk_out(29828, "R4 early", 0, 0, 1, 0);
    chk_out(29829, "R3 late half", 0, 1, 1, 0);
    chk_out(29830, "R5 line", 1, 0, 1, 1);
  endtask

  task automatic t_read;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(status_o[6] == 0, "R6 flag cleared", status_o[6], 0);
    check(irq_o == 0, "R6 line dropped", irq_o, 0);
  endtask

  task automatic t_five_step;
    int a;
    write(0, 8'h80, a);
    chk_out(a + 7457, "R7 even delay pre", 0, 0, 0, 0);
    chk_out(a + 7458, "R8 step0", 1, 0, 0, 0);
    chk_out(a + 7459, "R7 even delay post", 0, 0, 0, 0);
    chk_out(a + 14913, "R8 step1", 1, 1, 0, 0);
    chk_out(a + 29830, "R8 no quarter", 0, 0, 0, 0);
    chk_out(a + 37281, "R8 late half", 0, 1, 0, 0);
    chk_out(a + 37282, "R8 last", 1, 0, 0, 0);
  endtask

  task automatic t_inhibit;
    int a;
    write(1, 8'h40, a);
    chk_out(a + 7456, "R7 odd delay pre", 0, 0, 0, 0);
    chk_out(a + 7457, "R7 odd delay", 1, 0, 0, 0);
    chk_out(a + 29828, "R9 no early flag", 0, 0, 0, 0);
    chk_out(a + 29829, "R9 half", 0, 1, 0, 0);
    chk_out(a + 29830, "R9 no line", 1, 0, 0, 0);
  endtask

  task automatic t_inhibit_clear;
    int a, b;
    write(0, 8'h00, a);
    chk_out(a + 29830, "R4 set again", 1, 0, 1, 1);
    write(1, 8'h40, b);
    chk_out(b - 1, "R9 held", 0, 0, 1, 1);
    chk_out(b, "R9 cleared", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_four_step();
    t_read();
    t_five_step();
    t_inhibit();
    t_inhibit_clear();
    done = 1;
  end

  initial begin
    while (!done && cyc < 190000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule